// File: doc/BRIEF.md
# Pivot Search and Row Sequencer for Residue Gauss-Jordan Elimination

This unit does the pivot bookkeeping for a Gauss-Jordan solver that works in residue arithmetic and shifts the matrix one column left on every elimination step. While the rows of an n-row matrix are written, it follows the rows with a row counter and watches the first-column residue of each row. In each elimination step it takes the first nonzero residue found in a row that has not yet supplied a pivot. It records that row in a per-step pivot-index table, marks the row as used, and latches it for the reduction pass that follows. If a step ends with no pivot, the matrix is singular for this modulus.

The unit also supplies the shared row address for the matrix memory in three modes:
- **Search** (load or update): the row counter.
- **Reduction**: the pivot row first, then every other row in ascending order.
- **Readout**: the rows taken through the pivot-index table in step order, so the solution comes out in its proper order.

A sequencer drives it with one-cycle commands. The runtime dimension n may be any value from 2 up to the synthesis maximum.

Top module: `piv_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mem_addr` is 0 and `pivot_found` and `singular` are low.
- R2: In search mode, on an idle cycle (`cmd`=0) with `wr_en` high, the row counter shown on `mem_addr` advances by one. It wraps from n-1 to 0.
- R3: A write in search mode on an idle cycle is accepted as the pivot of the current step when all three hold: `wr_col0` is nonzero, the row at `mem_addr` has not supplied a pivot since the last solve, and no pivot has been accepted in this step. `pivot_found` then rises after that clock edge.
- R4: A write whose `wr_col0` is zero is never accepted.
- R5: A row that supplied a pivot in an earlier step is never accepted again, even when its value is nonzero.
- R6: Once a pivot is accepted, later nonzero writes in the same step do not replace it. `pivot_found` stays high until the next step or solve command.
- R7: The step command (`cmd`=2) lowers `pivot_found`, returns the row counter to 0 in search mode and moves to the next table entry. The entry index stops at n-1.
- R8: The close command (`cmd`=3) raises `singular` when no pivot was accepted in the current step. `singular` then stays high until the next solve command.
- R9: The reduce command (`cmd`=4) puts the current step's pivot row on `mem_addr`. Each `seq_adv` then steps through the other rows in ascending order, skipping the pivot row and holding at the last of them.
- R10: The read command (`cmd`=5) puts table entry 0 on `mem_addr`. Each `seq_adv` moves to the next entry, holding at entry n-1.
- R11: The solve command (`cmd`=1) clears all used-row marks, `pivot_found` and `singular`, and returns to search mode at row 0 and table entry 0.
- R12: The row counter, the table entry index and the reduction order are all bounded by the runtime `n_rows`, not by the synthesis maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| n_rows | input | $clog2(MAX_N)+1 | Runtime matrix dimension, 2..MAX_N |
| cmd | input | 3 | 0 idle, 1 solve, 2 step, 3 close, 4 reduce, 5 read |
| wr_en | input | 1 | A row is written at `mem_addr` this cycle |
| wr_col0 | input | VAL_W | First-column residue of the written row |
| seq_adv | input | 1 | Advance the reduction or readout order |
| mem_addr | output | $clog2(MAX_N) | Shared row address for the matrix memory |
| pivot_found | output | 1 | A pivot has been accepted in the current step |
| singular | output | 1 | Some step closed without a pivot since the last solve |

## Verification
The hardest case to reach is a nonzero residue arriving in a row that already gave a pivot. Only a solve run for several steps builds up used-row marks, and those marks are visible only through which row is later accepted and addressed. The stimulus runs four full steps on a 4-row matrix, placing nonzero values in already-used rows ahead of the fresh candidate. It also places the pivot at the first and the last row, so that the skip in the reduction order is exercised at both ends. A second solve after a singular outcome then checks that a row used earlier is accepted again.

// File: rtl/piv_pkg.sv
package piv_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_SOLVE  = 3'd1,
        CMD_STEP   = 3'd2,
        CMD_CLOSE  = 3'd3,
        CMD_REDUCE = 3'd4,
        CMD_READ   = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        MODE_SEARCH = 2'd0,
        MODE_REDUCE = 2'd1,
        MODE_READ   = 2'd2
    } mode_e;

    // Unused codes behave as idle.
    function automatic cmd_e decode_cmd(input logic [2:0] raw);
        case (raw)
            3'd1:    return CMD_SOLVE;
            3'd2:    return CMD_STEP;
            3'd3:    return CMD_CLOSE;
            3'd4:    return CMD_REDUCE;
            3'd5:    return CMD_READ;
            default: return CMD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/piv_search.sv
module piv_search
    import piv_pkg::*;
#(
    parameter int MAX_N = 8,
    parameter int VAL_W = 8,
    localparam int AW   = $clog2(MAX_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic [AW-1:0]    n_last,
    input  logic             search_on,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_row,
    input  logic [VAL_W-1:0] wr_col0,
    output logic             found,
    output logic             singular,
    output logic [AW-1:0]    piv_row,
    output logic             tbl_we,
    output logic [AW-1:0]    tbl_idx
);

    logic [MAX_N-1:0] used_q;
    logic [AW-1:0]    step_q;
    logic             accept;

    // Three-way qualification of a candidate residue.
    assign accept = search_on && wr_en && (cmd == CMD_IDLE)
                  && (wr_col0 != '0) && !used_q[wr_row] && !found;

    assign tbl_we  = accept;
    assign tbl_idx = step_q;

    always_ff @(posedge clk) begin
        if (rst || cmd == CMD_SOLVE) begin
            used_q   <= '0;
            found    <= 1'b0;
            singular <= 1'b0;
            piv_row  <= '0;
            step_q   <= '0;
        end else begin
            case (cmd)
                CMD_STEP: begin
                    found <= 1'b0;
                    if (step_q != n_last) step_q <= step_q + 1'b1;
                end
                CMD_CLOSE: begin
                    if (!found) singular <= 1'b1;
                end
                default: begin
                    if (accept) begin
                        used_q[wr_row] <= 1'b1;
                        found          <= 1'b1;
                        piv_row        <= wr_row;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/piv_table.sv
module piv_table #(
    parameter int MAX_N = 8,
    localparam int AW   = $clog2(MAX_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wr_idx,
    input  logic [AW-1:0] wr_row,
    input  logic [AW-1:0] rd_idx,
    output logic [AW-1:0] rd_row
);

    logic [AW-1:0] entry_q [MAX_N];

    for (genvar g = 0; g < MAX_N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (we && wr_idx == AW'(g)) begin
                entry_q[g] <= wr_row;
            end
        end
    end

    assign rd_row = entry_q[rd_idx];

endmodule

// File: rtl/piv_addr_seq.sv
module piv_addr_seq
    import piv_pkg::*;
#(
    parameter int MAX_N = 8,
    localparam int AW   = $clog2(MAX_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd,
    input  logic [AW-1:0] n_last,
    input  logic          wr_en,
    input  logic          seq_adv,
    input  logic [AW-1:0] piv_row,
    input  logic [AW-1:0] tbl_row,
    output logic [AW-1:0] cnt,
    output logic          search_on,
    output logic [AW-1:0] mem_addr
);

    mode_e       mode_q;
    logic        lead_q;
    logic [AW:0] inc1;
    logic [AW:0] skip;

    // Next reduction row: one up, jumping over the pivot row.
    assign inc1 = {1'b0, cnt} + 1'b1;
    assign skip = (inc1 == {1'b0, piv_row}) ? inc1 + 1'b1 : inc1;

    assign search_on = (mode_q == MODE_SEARCH);

    always_comb begin
        case (mode_q)
            MODE_REDUCE: mem_addr = lead_q ? piv_row : cnt;
            MODE_READ:   mem_addr = tbl_row;
            default:     mem_addr = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || cmd == CMD_SOLVE || cmd == CMD_STEP) begin
            mode_q <= MODE_SEARCH;
            cnt    <= '0;
            lead_q <= 1'b0;
        end else if (cmd == CMD_REDUCE) begin
            mode_q <= MODE_REDUCE;
            cnt    <= '0;
            lead_q <= 1'b1;
        end else if (cmd == CMD_READ) begin
            mode_q <= MODE_READ;
            cnt    <= '0;
            lead_q <= 1'b0;
        end else if (cmd == CMD_IDLE) begin
            case (mode_q)
                MODE_SEARCH: begin
                    if (wr_en) cnt <= (cnt == n_last) ? '0 : cnt + 1'b1;
                end
                MODE_REDUCE: begin
                    if (seq_adv) begin
                        if (lead_q) begin
                            lead_q <= 1'b0;
                            cnt    <= (piv_row == '0) ? AW'(1) : '0;
                        end else if (skip <= {1'b0, n_last}) begin
                            cnt <= skip[AW-1:0];
                        end
                    end
                end
                default: begin
                    if (seq_adv && cnt != n_last) cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/piv_unit.sv
module piv_unit
    import piv_pkg::*;
#(
    parameter int MAX_N = 8,
    parameter int VAL_W = 8,
    localparam int AW   = $clog2(MAX_N),
    localparam int NW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NW-1:0]    n_rows,
    input  logic [2:0]       cmd,
    input  logic             wr_en,
    input  logic [VAL_W-1:0] wr_col0,
    input  logic             seq_adv,
    output logic [AW-1:0]    mem_addr,
    output logic             pivot_found,
    output logic             singular
);

    cmd_e          cmd_d;
    logic [NW-1:0] n_m1;
    logic [AW-1:0] n_last;
    logic [AW-1:0] cnt;
    logic [AW-1:0] piv_row;
    logic [AW-1:0] tbl_row;
    logic [AW-1:0] tbl_idx;
    logic          tbl_we;
    logic          search_on;

    assign cmd_d  = decode_cmd(cmd);
    assign n_m1   = n_rows - 1'b1;
    assign n_last = n_m1[AW-1:0];

    piv_search #(.MAX_N(MAX_N), .VAL_W(VAL_W)) u_search (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd_d),
        .n_last    (n_last),
        .search_on (search_on),
        .wr_en     (wr_en),
        .wr_row    (cnt),
        .wr_col0   (wr_col0),
        .found     (pivot_found),
        .singular  (singular),
        .piv_row   (piv_row),
        .tbl_we    (tbl_we),
        .tbl_idx   (tbl_idx)
    );

    piv_table #(.MAX_N(MAX_N)) u_table (
        .clk    (clk),
        .rst    (rst),
        .we     (tbl_we),
        .wr_idx (tbl_idx),
        .wr_row (cnt),
        .rd_idx (cnt),
        .rd_row (tbl_row)
    );

    piv_addr_seq #(.MAX_N(MAX_N)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd_d),
        .n_last    (n_last),
        .wr_en     (wr_en),
        .seq_adv   (seq_adv),
        .piv_row   (piv_row),
        .tbl_row   (tbl_row),
        .cnt       (cnt),
        .search_on (search_on),
        .mem_addr  (mem_addr)
    );

endmodule

// File: rtl/piv_unit_chk.sv
module piv_unit_chk #(
    parameter int MAX_N = 8,
    parameter int VAL_W = 8,
    localparam int AW   = $clog2(MAX_N),
    localparam int NW   = AW + 1
) (
    input logic             clk,
    input logic             rst,
    input logic [NW-1:0]    n_rows,
    input logic [2:0]       cmd,
    input logic             wr_en,
    input logic [VAL_W-1:0] wr_col0,
    input logic [AW-1:0]    mem_addr,
    input logic             pivot_found,
    input logic             singular
);

    logic          range_ok;
    logic [NW-1:0] n_seen;

    // Range check is armed by a solve and disarmed if n changes afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            range_ok <= 1'b0;
            n_seen   <= '0;
        end else begin
            n_seen <= n_rows;
            if (cmd == 3'd1) range_ok <= 1'b1;
            else if (n_rows != n_seen) range_ok <= 1'b0;
        end
    end

    AST_FOUND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pivot_found && cmd != 3'd1 && cmd != 3'd2) |=> pivot_found); // R6

    AST_SINGULAR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (singular && cmd != 3'd1) |=> singular); // R8

    AST_SOLVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1) |=> (!pivot_found && !singular && mem_addr == '0)); // R11

    AST_FOUND_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(pivot_found) |-> $past(wr_en)); // R3

    AST_ZERO_REJECTED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_col0 == '0 && !pivot_found && cmd == 3'd0) |=> !pivot_found); // R4

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        range_ok |-> ({1'b0, mem_addr} < n_rows)); // R12

endmodule

bind piv_unit piv_unit_chk #(.MAX_N(MAX_N), .VAL_W(VAL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .n_rows      (n_rows),
    .cmd         (cmd),
    .wr_en       (wr_en),
    .wr_col0     (wr_col0),
    .mem_addr    (mem_addr),
    .pivot_found (pivot_found),
    .singular    (singular)
);

// File: tb/test_piv_unit.sv
module test_piv_unit;

    localparam int MAX_N = 8;
    localparam int VAL_W = 8;
    localparam int AW    = $clog2(MAX_N);
    localparam int NW    = AW + 1;

    typedef struct packed {
        logic [2:0] cmd;
        logic       wr;
        logic [7:0] val;
        logic       adv;
        logic [2:0] addr;
        logic       found;
        logic       sing;
        logic [3:0] req;
    } vec_t;

    // n = 4. Fields: cmd, wr, value, adv, expected addr, found, singular, requirement.
    localparam int NV = 47;
    localparam vec_t VEC [NV] = '{
        '{1,0, 0,0, 0,0,0, 11},  // solve
        '{0,1, 0,0, 1,0,0,  4},  // step 0: row0 zero, rejected (R4)
        '{0,1, 5,0, 2,1,0,  3},  // row1 accepted (R3)
        '{0,1, 7,0, 3,1,0,  6},  // row2 ignored (R6)
        '{0,1, 3,0, 0,1,0,  2},  // counter wraps (R2)
        '{3,0, 0,0, 0,1,0,  8},
        '{4,0, 0,0, 1,1,0,  9},  // reduce: pivot row 1 first (R9)
        '{0,0, 0,1, 0,1,0,  9},
        '{0,0, 0,1, 2,1,0,  9},  // skips row 1
        '{0,0, 0,1, 3,1,0,  9},
        '{0,0, 0,1, 3,1,0,  9},  // holds
        '{2,0, 0,0, 0,0,0,  7},  // step 1 (R7)
        '{0,1, 0,0, 1,0,0,  4},
        '{0,1, 9,0, 2,0,0,  5},  // row1 used earlier (R5)
        '{0,1, 4,0, 3,1,0,  3},  // row2 accepted
        '{0,1, 6,0, 0,1,0,  6},
        '{3,0, 0,0, 0,1,0,  8},
        '{4,0, 0,0, 2,1,0,  9},
        '{0,0, 0,1, 0,1,0,  9},
        '{0,0, 0,1, 1,1,0,  9},
        '{0,0, 0,1, 3,1,0,  9},  // skips row 2
        '{0,0, 0,1, 3,1,0,  9},
        '{2,0, 0,0, 0,0,0,  7},  // step 2
        '{0,1, 0,0, 1,0,0,  4},
        '{0,1, 8,0, 2,0,0,  5},
        '{0,1, 1,0, 3,0,0,  5},
        '{0,1, 2,0, 0,1,0,  3},  // row3 accepted
        '{3,0, 0,0, 0,1,0,  8},
        '{4,0, 0,0, 3,1,0,  9},  // pivot at last row
        '{0,0, 0,1, 0,1,0,  9},
        '{0,0, 0,1, 1,1,0,  9},
        '{0,0, 0,1, 2,1,0,  9},
        '{0,0, 0,1, 2,1,0,  9},  // holds at row 2
        '{2,0, 0,0, 0,0,0,  7},  // step 3
        '{0,1,11,0, 1,1,0,  3},  // row0 accepted
        '{0,1, 5,0, 2,1,0,  5},
        '{3,0, 0,0, 2,1,0,  8},
        '{4,0, 0,0, 0,1,0,  9},  // pivot at row 0
        '{0,0, 0,1, 1,1,0,  9},
        '{0,0, 0,1, 2,1,0,  9},
        '{0,0, 0,1, 3,1,0,  9},
        '{0,0, 0,1, 3,1,0,  9},
        '{5,0, 0,0, 1,1,0, 10},  // readout through table: 1,2,3,0 (R10)
        '{0,0, 0,1, 2,1,0, 10},
        '{0,0, 0,1, 3,1,0, 10},
        '{0,0, 0,1, 0,1,0, 10},
        '{0,0, 0,1, 0,1,0, 10}   // holds at entry n-1
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NW-1:0]    n_rows = NW'(4);
    logic [2:0]       cmd = 3'd0;
    logic             wr_en = 1'b0;
    logic [VAL_W-1:0] wr_col0 = '0;
    logic             seq_adv = 1'b0;
    logic [AW-1:0]    mem_addr;
    logic             pivot_found;
    logic             singular;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    piv_unit #(.MAX_N(MAX_N), .VAL_W(VAL_W)) i_piv_unit (
        .clk         (clk),
        .rst         (rst),
        .n_rows      (n_rows),
        .cmd         (cmd),
        .wr_en       (wr_en),
        .wr_col0     (wr_col0),
        .seq_adv     (seq_adv),
        .mem_addr    (mem_addr),
        .pivot_found (pivot_found),
        .singular    (singular)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Drives one cycle's inputs, waits past the edge, then returns to idle.
    task automatic cyc(input int c, input int w, input int v, input int a);
        cmd = 3'(c); wr_en = w[0]; wr_col0 = VAL_W'(v); seq_adv = a[0];
        @(posedge clk);
        #1;
        cmd = 3'd0; wr_en = 1'b0; wr_col0 = '0; seq_adv = 1'b0;
    endtask

    task automatic check(input int req, input int ea, input int ef, input int es);
        checks++;
        if (mem_addr != AW'(ea) || pivot_found != ef[0] || singular != es[0]) begin
            fails++;
            $display("FAIL R%0d: addr=%0d found=%0d singular=%0d expected addr=%0d found=%0d singular=%0d",
                     req, mem_addr, pivot_found, singular, ea, ef, es);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1, 0, 0, 0);          // R1 during reset
        rst = 1'b0;
        cyc(0, 0, 0, 0);
        check(1, 0, 0, 0);          // R1 after reset

        for (int i = 0; i < NV; i++) begin
            cyc(int'(VEC[i].cmd), int'(VEC[i].wr), int'(VEC[i].val), int'(VEC[i].adv));
            check(int'(VEC[i].req), int'(VEC[i].addr), int'(VEC[i].found), int'(VEC[i].sing));
        end

        // R8: a step closing with only zero values marks the matrix singular.
        cyc(1, 0, 0, 0);
        check(11, 0, 0, 0);
        for (int r = 0; r < 4; r++) cyc(0, 1, 0, 0);
        check(4, 0, 0, 0);
        cyc(3, 0, 0, 0);
        check(8, 0, 0, 1);
        cyc(2, 0, 0, 0);
        check(8, 0, 0, 1);          // R8 sticky across a step
        cyc(1, 0, 0, 0);
        check(11, 0, 0, 0);         // R11 solve clears singular

        // R11: row 1 was used in the earlier solve; it must be accepted again.
        cyc(0, 1, 0, 0);
        cyc(0, 1, 6, 0);
        check(11, 2, 1, 0);
        cyc(3, 0, 0, 0);
        cyc(4, 0, 0, 0);
        check(11, 1, 1, 0);

        // R12: runtime n = 2 bounds all counters.
        n_rows = NW'(2);
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, 0);
        check(12, 1, 0, 0);
        cyc(0, 1, 0, 0);
        check(12, 0, 0, 0);         // wraps at n-1 = 1
        cyc(0, 1, 3, 0);
        check(12, 1, 1, 0);         // row 0 accepted
        cyc(0, 1, 4, 0);
        check(12, 0, 1, 0);
        cyc(3, 0, 0, 0);
        cyc(4, 0, 0, 0);
        check(12, 0, 1, 0);
        cyc(0, 0, 0, 1);
        check(12, 1, 1, 0);
        cyc(0, 0, 0, 1);
        check(12, 1, 1, 0);         // holds at row 1
        cyc(2, 0, 0, 0);
        cyc(0, 1, 3, 0);
        check(5, 1, 0, 0);          // row 0 used: rejected
        cyc(0, 1, 4, 0);
        check(12, 0, 1, 0);         // row 1 accepted into entry 1
        cyc(3, 0, 0, 0);
        cyc(5, 0, 0, 0);
        check(10, 0, 1, 0);
        cyc(0, 0, 0, 1);
        check(10, 1, 1, 0);
        cyc(0, 0, 0, 1);
        check(12, 1, 1, 0);         // readout holds at entry n-1 = 1

        finish_run();
    end

endmodule